// File: doc/BRIEF.md
# Trusted-Module Interrupt Enable and Status Unit

This unit is the device-side interrupt logic of a trusted-module register interface. Four event pulses from the rest of the module (data available, status valid, locality change, command ready) are latched into a pending-status register. A source is latched only when its own enable bit is set. The host clears pending bits by writing ones to them. The host controls an enable register that holds one bit per source and a global enable bit, and it can read and write an 8-bit interrupt line number. A read-only capability register reports which sources exist, whether the burst count is static, and how the single interrupt output signals.

The output signalling style is fixed at build time by a parameter. It can be active-high level, active-low level, a rising-edge pulse or a falling-edge pulse. In the level styles the line stays active while any enabled pending bit exists and the global enable is set. In the edge styles the line gives one active cycle each time a pending bit becomes active. Host accesses come through a simple register port: a single-cycle write strobe, or a read strobe whose data returns registered one cycle later with a valid flag.

Top module: `tmi_irq_ctrl`

## Requirements
- R1: After reset the enable, status and vector registers read 0, and the interrupt output is at its inactive level (0 for active-high styles, 1 for active-low styles).
- R2: The enable register at byte offset 0x08 stores bit 0 (data available), bit 1 (status valid), bit 2 (locality change), bit 7 (command ready) and bit 31 (global enable). All other bits read as 0.
- R3: The vector register at offset 0x0C stores the low 8 bits written, and bits 31:8 read as 0.
- R4: The capability register at offset 0x14 reads 1 in bits 0, 1, 2 and 7. Bit 8 reads the static-burst parameter. Exactly one of bits 3 (level high), 4 (level low), 5 (rising edge) and 6 (falling edge) reads 1, matching the signalling parameter. Writes to this register have no effect.
- R5: The status register at offset 0x10 uses the same bit positions as the enable sources. An event pulse sets its bit on the next clock when that source's enable bit is set. An event whose source enable is 0 leaves the bit at 0.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Writing back the value just read clears every pending bit.
- R7: When an event and a write-1 clear of the same status bit arrive in the same cycle, the bit stays set.
- R8: In a level style the output becomes active one clock after some status bit and its enable bit are both 1 with the global enable set. It returns to inactive one clock after no such pair remains.
- R9: Clearing the global enable makes the output inactive one clock later, and the per-source enable bits and pending status bits are kept. Setting the global enable again reactivates the output.
- R10: In an edge style the output is active for exactly one clock, starting one clock after an enabled pending bit becomes active. It stays inactive while that bit remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset within the register window |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| ev_data_avail | input | 1 | Data-available event pulse |
| ev_sts_valid | input | 1 | Status-valid event pulse |
| ev_loc_change | input | 1 | Locality-change event pulse |
| ev_cmd_ready | input | 1 | Command-ready event pulse |
| irq | output | 1 | Interrupt line in the configured style |

## Verification
Two functions can act on the same status bit in the same clock: an incoming event that sets the bit and a host write-1 that clears it. The bench raises the data-available pulse in the same cycle as a status write that has bit 0 set. It then reads the status back through the scoreboard, and the bit must still be 1. In a separate step, a write-back of the value just read, with no event present, must clear the register to 0 and drop the interrupt line one cycle later.

// File: rtl/tmi_irq_pkg.sv
// Shared constants, types and helpers for the interrupt unit.
// Assumes a 32-bit register word and a fixed set of four event sources.
package tmi_irq_pkg;

    localparam int REG_W   = 32;
    localparam int NUM_SRC = 4;
    localparam int VEC_W   = 8;

    localparam int OFF_ENABLE = 'h08;
    localparam int OFF_VECTOR = 'h0C;
    localparam int OFF_STATUS = 'h10;
    localparam int OFF_CAPS   = 'h14;

    localparam int GLOBAL_BIT       = 31;
    localparam int STATIC_BURST_BIT = 8;
    localparam int MODE_BIT_BASE    = 3;

    typedef enum logic [1:0] {
        SIG_LEVEL_HIGH   = 2'd0,
        SIG_LEVEL_LOW    = 2'd1,
        SIG_EDGE_RISING  = 2'd2,
        SIG_EDGE_FALLING = 2'd3
    } sig_mode_e;

    // Register bit position of compact source index i.
    function automatic int src_pos(input int i);
        case (i)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            default: return 7;
        endcase
    endfunction

    // Constant capability word for a given style and burst setting.
    function automatic logic [REG_W-1:0] caps_word(input sig_mode_e m, input bit static_burst);
        logic [REG_W-1:0] w;
        w = '0;
        for (int i = 0; i < NUM_SRC; i++) w[src_pos(i)] = 1'b1;
        w[MODE_BIT_BASE + int'(m)] = 1'b1;
        w[STATIC_BURST_BIT] = static_burst;
        return w;
    endfunction

    function automatic bit mode_is_low(input sig_mode_e m);
        return (m == SIG_LEVEL_LOW) || (m == SIG_EDGE_FALLING);
    endfunction

    function automatic bit mode_is_edge(input sig_mode_e m);
        return (m == SIG_EDGE_RISING) || (m == SIG_EDGE_FALLING);
    endfunction

endpackage

// File: rtl/tmi_irq_regs.sv
// Holds the per-source enables, the global enable and the line number.
// Assumes the write strobes are single-cycle and already address-decoded.
module tmi_irq_regs
    import tmi_irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int V_W   = VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we,
    input  logic [N_SRC-1:0] en_wsrc,
    input  logic             en_wglb,
    input  logic             vec_we,
    input  logic [V_W-1:0]   vec_wdata,
    output logic [N_SRC-1:0] src_en,
    output logic             glb_en,
    output logic [V_W-1:0]   vec_q
);

    // Enable bits: loaded whole on an enable write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en <= '0;
            glb_en <= 1'b0;
        end else if (en_we) begin
            src_en <= en_wsrc;
            glb_en <= en_wglb;
        end
    end

    // Line number: loaded on a vector write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= '0;
        else if (vec_we)
            vec_q <= vec_wdata;
    end

    assert_vector_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_we |=> $stable(vec_q));

    assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we |=> ($stable(src_en) && $stable(glb_en)));

endmodule

// File: rtl/tmi_irq_status.sv
// Pending-event register with write-1-to-clear.
// Assumes event inputs are one-cycle pulses; a set in the same cycle
// as a clear takes priority.
module tmi_irq_status
    import tmi_irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ev,
    input  logic [N_SRC-1:0] src_en,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] pend
);

    logic [N_SRC-1:0] set_v;

    // Events are latched only for enabled sources.
    always_comb set_v = ev & src_en;

    // Pending bits: clear first, then set, so set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else
            pend <= (pend & ~clr) | set_v;
    end

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((pend & $past(set_v)) == $past(set_v)));

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set_v)) |=> ((pend & $past(clr & ~set_v)) == '0));

    assert_masked_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend == '0) && ((ev & src_en) == '0)) |=> (pend == '0));

endmodule

// File: rtl/tmi_irq_outgen.sv
// Drives the interrupt line in the style chosen by MODE.
// Assumes pend and src_en come straight from registers.
module tmi_irq_outgen
    import tmi_irq_pkg::*;
#(
    parameter int        N_SRC = NUM_SRC,
    parameter sig_mode_e MODE  = SIG_LEVEL_HIGH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] src_en,
    input  logic             glb_en,
    output logic             irq
);

    localparam bit ACT_LOW = mode_is_low(MODE);
    localparam bit IS_EDGE = mode_is_edge(MODE);

    logic [N_SRC-1:0] live;
    logic             req;
    logic             act_q;

    // Enabled pending sources, masked by the global enable.
    always_comb begin
        live = pend & src_en & {N_SRC{glb_en}};
        req  = |live;
    end

    generate
        if (IS_EDGE) begin : g_edge
            logic [N_SRC-1:0] live_prev;

            // Pulse on any source that became live this cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    live_prev <= '0;
                    act_q     <= 1'b0;
                end else begin
                    live_prev <= live;
                    act_q     <= |(live & ~live_prev);
                end
            end

            assert_no_pulse_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (!req) |=> !act_q);

            assert_pulse_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
                ($stable(live) && $past(rst_n)) |=> !act_q);
        end else begin : g_level
            // Level follows the request one clock later.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    act_q <= 1'b0;
                else
                    act_q <= req;
            end

            assert_level_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
                req |=> act_q);

            assert_global_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !glb_en |=> !act_q);
        end
    endgenerate

    // Apply the polarity.
    always_comb irq = act_q ^ ACT_LOW;

endmodule

// File: rtl/tmi_irq_ctrl.sv
// Top of the interrupt unit: address decode, bit packing, read port.
// Assumes at most one of reg_wr / reg_rd per cycle; reads return
// registered data one clock after the strobe.
module tmi_irq_ctrl
    import tmi_irq_pkg::*;
#(
    parameter int        ADDR_W       = 12,
    parameter sig_mode_e MODE         = SIG_LEVEL_HIGH,
    parameter bit        STATIC_BURST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              reg_rvalid,
    input  logic              ev_data_avail,
    input  logic              ev_sts_valid,
    input  logic              ev_loc_change,
    input  logic              ev_cmd_ready,
    output logic              irq
);

    localparam logic [REG_W-1:0] CAPS = caps_word(MODE, STATIC_BURST);

    logic              sel_en, sel_vec, sel_st, sel_cap;
    logic [NUM_SRC-1:0] ev_v, src_en, pend, clr_v, wsrc;
    logic              glb_en;
    logic [VEC_W-1:0]  vec_q;
    logic [REG_W-1:0]  en_word, st_word, rd_mux;

    // Offset decode within the window.
    always_comb begin
        sel_en  = (reg_addr == ADDR_W'(OFF_ENABLE));
        sel_vec = (reg_addr == ADDR_W'(OFF_VECTOR));
        sel_st  = (reg_addr == ADDR_W'(OFF_STATUS));
        sel_cap = (reg_addr == ADDR_W'(OFF_CAPS));
    end

    assign ev_v = {ev_cmd_ready, ev_loc_change, ev_sts_valid, ev_data_avail};

    // Map each compact source to its register bit.
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_map
            localparam int P = src_pos(i);
            assign wsrc[i]  = reg_wdata[P];
            assign clr_v[i] = reg_wr && sel_st && reg_wdata[P];
        end
    endgenerate

    // Spread the compact vectors into register words.
    always_comb begin
        en_word = '0;
        st_word = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            en_word[src_pos(i)] = src_en[i];
            st_word[src_pos(i)] = pend[i];
        end
        en_word[GLOBAL_BIT] = glb_en;
    end

    tmi_irq_regs #(.N_SRC(NUM_SRC), .V_W(VEC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_we     (reg_wr && sel_en),
        .en_wsrc   (wsrc),
        .en_wglb   (reg_wdata[GLOBAL_BIT]),
        .vec_we    (reg_wr && sel_vec),
        .vec_wdata (reg_wdata[VEC_W-1:0]),
        .src_en    (src_en),
        .glb_en    (glb_en),
        .vec_q     (vec_q)
    );

    tmi_irq_status #(.N_SRC(NUM_SRC)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_v),
        .src_en (src_en),
        .clr    (clr_v),
        .pend   (pend)
    );

    tmi_irq_outgen #(.N_SRC(NUM_SRC), .MODE(MODE)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend),
        .src_en (src_en),
        .glb_en (glb_en),
        .irq    (irq)
    );

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        if (sel_en)  rd_mux = en_word;
        if (sel_vec) rd_mux = {{(REG_W-VEC_W){1'b0}}, vec_q};
        if (sel_st)  rd_mux = st_word;
        if (sel_cap) rd_mux = CAPS;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

    assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    assert_caps_constant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel_cap) |=> (reg_rdata == CAPS));

endmodule

// File: tb/test_tmi_irq_ctrl.sv
module test_tmi_irq_ctrl;
    import tmi_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata, rdata_e;
    logic        reg_rvalid, rvalid_e;
    logic [3:0]  ev = '0;   // {cmd_ready, loc_change, sts_valid, data_avail}
    logic        irq, irq_e;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    tmi_irq_ctrl i_tmi_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .ev_data_avail(ev[0]), .ev_sts_valid(ev[1]),
        .ev_loc_change(ev[2]), .ev_cmd_ready(ev[3]), .irq(irq)
    );

    tmi_irq_ctrl #(.MODE(SIG_EDGE_FALLING), .STATIC_BURST(1'b0)) i_tmi_irq_ctrl_edge (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(rdata_e),
        .reg_rvalid(rvalid_e), .ev_data_avail(ev[0]), .ev_sts_valid(ev[1]),
        .ev_loc_change(ev[2]), .ev_cmd_ready(ev[3]), .irq(irq_e)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compare each returned read with the queue head.
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("SB unexpected read", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, reg_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] evs = 4'h0);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; ev = evs;
        @(negedge clk);
        reg_wr = 1'b0; ev = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_ev(input logic [3:0] evs);
        @(negedge clk);
        ev = evs;
        @(negedge clk);
        ev = '0;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog expired", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq level-high idle", {31'b0, irq}, 32'h0);
        chk("R1 irq falling-edge idle", {31'b0, irq_e}, 32'h1);
        bus_read(12'h008, 32'h0, "R1 enable reset");
        bus_read(12'h010, 32'h0, "R1 status reset");
        bus_read(12'h00C, 32'h0, "R1 vector reset");

        // R4: capabilities, both builds, and write ignored
        bus_read(12'h014, 32'h0000_018F, "R4 caps level-high");
        chk("R4 caps falling-edge", rdata_e, 32'h0000_00C7);
        bus_write(12'h014, 32'hFFFF_FFFF);
        bus_read(12'h014, 32'h0000_018F, "R4 caps after write");

        // R2: writable enable bits
        bus_write(12'h008, 32'hFFFF_FFFF);
        bus_read(12'h008, 32'h8000_0087, "R2 enable mask");

        // R3: vector width
        bus_write(12'h00C, 32'h1234_56AB);
        bus_read(12'h00C, 32'h0000_00AB, "R3 vector");

        // R5: disabled source not latched
        bus_write(12'h008, 32'h8000_0001);
        pulse_ev(4'b0100);
        bus_read(12'h010, 32'h0, "R5 masked event");
        chk("R5 irq stays idle", {31'b0, irq}, 32'h0);

        // R5/R8/R10: enabled event
        pulse_ev(4'b0001);
        chk("R8 irq not before one clock", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R8 irq active", {31'b0, irq}, 32'h1);
        chk("R10 edge pulse active low", {31'b0, irq_e}, 32'h0);
        @(negedge clk);
        chk("R10 edge pulse one cycle", {31'b0, irq_e}, 32'h1);
        @(negedge clk);
        chk("R10 no repeat pulse", {31'b0, irq_e}, 32'h1);
        bus_read(12'h010, 32'h1, "R5 event latched");

        // R9: global enable masks, keeps state
        bus_write(12'h008, 32'h0000_0001);
        @(negedge clk);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        bus_read(12'h010, 32'h1, "R9 status kept");
        bus_read(12'h008, 32'h0000_0001, "R9 source enable kept");
        bus_write(12'h008, 32'h8000_0087);
        @(negedge clk);
        chk("R9 irq reactivated", {31'b0, irq}, 32'h1);

        // R6: write-1-to-clear
        pulse_ev(4'b1010);
        bus_read(12'h010, 32'h83, "R5 two events latched");
        bus_write(12'h010, 32'h0000_0002);
        bus_read(12'h010, 32'h81, "R6 single bit cleared");
        bus_write(12'h010, 32'h0);
        bus_read(12'h010, 32'h81, "R6 zero write no effect");

        // R7: event and clear in the same cycle
        bus_write(12'h010, 32'h0000_0001, 4'b0001);
        bus_read(12'h010, 32'h81, "R7 event wins over clear");

        // R6/R8: write-back clears all, line drops
        bus_write(12'h010, 32'h81);
        @(negedge clk);
        chk("R8 irq released", {31'b0, irq}, 32'h0);
        bus_read(12'h010, 32'h0, "R6 write-back clears all");

        repeat (3) @(negedge clk);
        chk("SB queue drained", exp_q.size(), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule